// File: doc/BRIEF.md
# Register-Pair Signed Divider

This unit performs signed fixed-point division for a processor's integer datapath. Each operation names a register R by a 4-bit field. The register file supplies the contents of R and of its partner R|1 as read data. The unit forms the dividend and runs a shift-and-subtract loop on magnitudes, one quotient bit per cycle. It then corrects the signs of quotient and remainder and hands back write requests for the register file, together with condition-code updates.

There are two word forms and one halfword form:

- **Word divide, even R:** registers R and R|1 together form a signed double-width dividend. The remainder goes back to R and the quotient to R|1.
- **Word divide, odd R:** register R alone is sign-extended to double width. Only the quotient is written back.
- **Halfword divide:** register R is divided by a sign-extended 16-bit divisor.

A quotient that does not fit the signed word range is an overflow. A zero divisor also counts as overflow. On overflow nothing is written except the overflow condition bit, and a trap request to a fixed vector is raised when the arithmetic trap mask is set.

Top module: `regdiv_unit`

## Requirements
- R1: Word divide (`op_word_i`=1) with even `reg_sel_i` divides the signed 64-bit value {`rd_r_i`,`rd_r1_i`} by `divisor_i`. At done it writes the remainder to address R (`wr_r_addr_o`) and the quotient to address R|1 (`wr_r1_addr_o`), with both write enables high.
- R2: The quotient is truncated toward zero. A nonzero remainder carries the sign of the dividend.
- R3: Word divide with odd `reg_sel_i` sign-extends `rd_r_i` to 64 bits and ignores `rd_r1_i`. It writes the quotient to R only and keeps `wr_r1_en_o` low.
- R4: Halfword divide (`op_word_i`=0) divides the signed word `rd_r_i` by the sign extension of `divisor_i[15:0]`, ignoring the upper divisor bits. It writes the quotient to R only, for even or odd R.
- R5: A zero divisor, or a quotient outside [-2^31, 2^31-1], is an overflow. At done, `cc2_we_o`=1 and `cc2_o`=1, while `cc34_we_o`, `wr_r_en_o` and `wr_r1_en_o` are all 0.
- R6: Without overflow, at done `cc2_we_o`=1 with `cc2_o`=0, and `cc34_we_o`=1 with `cc34_o` set to 00 for a zero quotient, 01 for a negative one, and 10 for a positive one.
- R7: `trap_o` pulses with done exactly when an overflow occurs and `trap_mask_i` was 1 at start. `trap_vec_o` is 0x43.
- R8: `done_o` is high for one cycle. Taking the start edge as edge 0, done appears after edge 1 when the divisor is zero or the upper dividend half's magnitude is at least the divisor's magnitude. In every other case it appears after edge ITER+2 (34).
- R9: `busy_o` rises after an accepted start and falls after done. A `start_i` seen while busy is ignored and does not disturb the running result.
- R10: After reset, `done_o`, `busy_o`, `trap_o` and all write enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation (accepted when idle) |
| op_word_i | input | 1 | 1 = word divide, 0 = halfword divide |
| reg_sel_i | input | 4 | Register field R |
| divisor_i | input | 32 | Effective divisor operand |
| rd_r_i | input | 32 | Contents of register R |
| rd_r1_i | input | 32 | Contents of register R\|1 |
| trap_mask_i | input | 1 | Arithmetic trap mask |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wr_r_en_o | output | 1 | Write enable for register R |
| wr_r_addr_o | output | 4 | Address R |
| wr_r_data_o | output | 32 | Data for R (remainder or quotient) |
| wr_r1_en_o | output | 1 | Write enable for register R\|1 |
| wr_r1_addr_o | output | 4 | Address R\|1 |
| wr_r1_data_o | output | 32 | Quotient for R\|1 |
| cc2_we_o | output | 1 | Overflow condition bit update |
| cc2_o | output | 1 | Overflow condition bit value |
| cc34_we_o | output | 1 | Sign condition bits update |
| cc34_o | output | 2 | Sign condition code of quotient |
| trap_o | output | 1 | Trap request |
| trap_vec_o | output | 8 | Trap vector |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, 16-bit halfword and 32 iterations. This puts the exact signed-word boundaries in reach: -2^31 passes and +2^31 overflows, as does the halfword case -2^31 / -1. It also exercises both latency paths, the early overflow exit and the full iteration run, each against its exact cycle count. Every cycle of each operation is compared with a behavioural model that uses 64-bit integer division, including a stray start pulse injected in mid-run.

// File: rtl/regdiv_pkg.sv
package regdiv_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_RUN,
    S_FIX,
    S_FIN
  } div_state_e;

  localparam logic [1:0] CC_ZERO = 2'b00;
  localparam logic [1:0] CC_NEG  = 2'b01;
  localparam logic [1:0] CC_POS  = 2'b10;
endpackage

// File: rtl/regdiv_prep.sv
module regdiv_prep #(
  parameter int XLEN = 32,
  parameter int HLEN = 16
) (
  input  logic              op_word_i,
  input  logic              r_odd_i,
  input  logic [XLEN-1:0]   rd_r_i,
  input  logic [XLEN-1:0]   rd_r1_i,
  input  logic [XLEN-1:0]   divisor_i,
  output logic              pair_o,
  output logic              dvd_neg_o,
  output logic              dsr_neg_o,
  output logic [2*XLEN-1:0] dvd_mag_o,
  output logic [XLEN-1:0]   dsr_mag_o
);
  logic [2*XLEN-1:0] dvd;
  logic [XLEN-1:0]   dsr;

  assign pair_o = op_word_i & ~r_odd_i;

  always_comb begin
    if (pair_o) dvd = {rd_r_i, rd_r1_i};
    else        dvd = {{XLEN{rd_r_i[XLEN-1]}}, rd_r_i};
    if (op_word_i) dsr = divisor_i;
    else           dsr = {{(XLEN-HLEN){divisor_i[HLEN-1]}}, divisor_i[HLEN-1:0]};
  end

  assign dvd_neg_o = dvd[2*XLEN-1];
  assign dsr_neg_o = dsr[XLEN-1];
  assign dvd_mag_o = dvd_neg_o ? (~dvd + 1'b1) : dvd;
  assign dsr_mag_o = dsr_neg_o ? (~dsr + 1'b1) : dsr;
endmodule

// File: rtl/regdiv_core.sv
module regdiv_core #(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            step_i,
  input  logic [XLEN-1:0] rem_init_i,
  input  logic [XLEN-1:0] num_lo_i,
  input  logic [XLEN-1:0] den_i,
  output logic [XLEN-1:0] quo_o,
  output logic [XLEN-1:0] rem_o
);
  logic [XLEN-1:0] rem_q, quo_q;
  logic [XLEN:0]   trial;
  logic            fits;

  // quo_q shifts out dividend bits while quotient bits shift in
  assign trial = {rem_q, quo_q[XLEN-1]};
  assign fits  = trial >= {1'b0, den_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
    end else if (load_i) begin
      rem_q <= rem_init_i;
      quo_q <= num_lo_i;
    end else if (step_i) begin
      rem_q <= fits ? XLEN'(trial - {1'b0, den_i}) : trial[XLEN-1:0];
      quo_q <= {quo_q[XLEN-2:0], fits};
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;
endmodule

// File: rtl/regdiv_post.sv
module regdiv_post #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] quo_mag_i,
  input  logic [XLEN-1:0] rem_mag_i,
  input  logic            dvd_neg_i,
  input  logic            dsr_neg_i,
  output logic [XLEN-1:0] quo_o,
  output logic [XLEN-1:0] rem_o,
  output logic            range_ovf_o,
  output logic [1:0]      cc34_o
);
  import regdiv_pkg::*;
  localparam logic [XLEN-1:0] MIN_MAG = {1'b1, {(XLEN-1){1'b0}}};

  logic q_neg;
  assign q_neg       = dvd_neg_i ^ dsr_neg_i;
  assign range_ovf_o = q_neg ? (quo_mag_i > MIN_MAG) : quo_mag_i[XLEN-1];
  assign quo_o       = q_neg ? (~quo_mag_i + 1'b1) : quo_mag_i;
  assign rem_o       = dvd_neg_i ? (~rem_mag_i + 1'b1) : rem_mag_i;

  always_comb begin
    if (quo_mag_i == '0) cc34_o = CC_ZERO;
    else if (q_neg)      cc34_o = CC_NEG;
    else                 cc34_o = CC_POS;
  end
endmodule

// File: rtl/regdiv_unit.sv
module regdiv_unit #(
  parameter int               XLEN     = 32,
  parameter int               HLEN     = 16,
  parameter int               REG_W    = 4,
  parameter int               VEC_W    = 8,
  parameter logic [VEC_W-1:0] TRAP_VEC = 8'h43
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             op_word_i,
  input  logic [REG_W-1:0] reg_sel_i,
  input  logic [XLEN-1:0]  divisor_i,
  input  logic [XLEN-1:0]  rd_r_i,
  input  logic [XLEN-1:0]  rd_r1_i,
  input  logic             trap_mask_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             wr_r_en_o,
  output logic [REG_W-1:0] wr_r_addr_o,
  output logic [XLEN-1:0]  wr_r_data_o,
  output logic             wr_r1_en_o,
  output logic [REG_W-1:0] wr_r1_addr_o,
  output logic [XLEN-1:0]  wr_r1_data_o,
  output logic             cc2_we_o,
  output logic             cc2_o,
  output logic             cc34_we_o,
  output logic [1:0]       cc34_o,
  output logic             trap_o,
  output logic [VEC_W-1:0] trap_vec_o
);
  import regdiv_pkg::*;

  localparam int ITER  = XLEN;
  localparam int CNT_W = $clog2(ITER);

  div_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              pair_q, mask_q, dvd_neg_q, dsr_neg_q, ovf_q;
  logic [REG_W-1:0]  reg_q;
  logic [XLEN-1:0]   dvd_hi_q, dsr_mag_q, quo_q, rem_q;
  logic [1:0]        cc34_q;

  logic              accept;
  logic              pr_pair, pr_dvd_neg, pr_dsr_neg;
  logic [2*XLEN-1:0] pr_dvd_mag;
  logic [XLEN-1:0]   pr_dsr_mag;
  logic [XLEN-1:0]   core_quo, core_rem;
  logic [XLEN-1:0]   po_quo, po_rem;
  logic              po_ovf;
  logic [1:0]        po_cc34;

  assign accept = start_i && (state_q == S_IDLE);

  regdiv_prep #(.XLEN(XLEN), .HLEN(HLEN)) u_prep (
    .op_word_i (op_word_i),
    .r_odd_i   (reg_sel_i[0]),
    .rd_r_i    (rd_r_i),
    .rd_r1_i   (rd_r1_i),
    .divisor_i (divisor_i),
    .pair_o    (pr_pair),
    .dvd_neg_o (pr_dvd_neg),
    .dsr_neg_o (pr_dsr_neg),
    .dvd_mag_o (pr_dvd_mag),
    .dsr_mag_o (pr_dsr_mag)
  );

  regdiv_core #(.XLEN(XLEN)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .step_i     (state_q == S_RUN),
    .rem_init_i (pr_dvd_mag[2*XLEN-1:XLEN]),
    .num_lo_i   (pr_dvd_mag[XLEN-1:0]),
    .den_i      (dsr_mag_q),
    .quo_o      (core_quo),
    .rem_o      (core_rem)
  );

  regdiv_post #(.XLEN(XLEN)) u_post (
    .quo_mag_i   (core_quo),
    .rem_mag_i   (core_rem),
    .dvd_neg_i   (dvd_neg_q),
    .dsr_neg_i   (dsr_neg_q),
    .quo_o       (po_quo),
    .rem_o       (po_rem),
    .range_ovf_o (po_ovf),
    .cc34_o      (po_cc34)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      cnt_q     <= '0;
      pair_q    <= 1'b0;
      mask_q    <= 1'b0;
      dvd_neg_q <= 1'b0;
      dsr_neg_q <= 1'b0;
      ovf_q     <= 1'b0;
      reg_q     <= '0;
      dvd_hi_q  <= '0;
      dsr_mag_q <= '0;
      quo_q     <= '0;
      rem_q     <= '0;
      cc34_q    <= 2'b00;
    end else begin
      unique case (state_q)
        S_IDLE: if (accept) begin
          pair_q    <= pr_pair;
          mask_q    <= trap_mask_i;
          dvd_neg_q <= pr_dvd_neg;
          dsr_neg_q <= pr_dsr_neg;
          reg_q     <= reg_sel_i;
          dvd_hi_q  <= pr_dvd_mag[2*XLEN-1:XLEN];
          dsr_mag_q <= pr_dsr_mag;
          ovf_q     <= 1'b0;
          state_q   <= S_CHECK;
        end
        S_CHECK: begin
          // quotient of at least 2^XLEN, or zero divisor: skip the loop
          if (dsr_mag_q == '0 || dvd_hi_q >= dsr_mag_q) begin
            ovf_q   <= 1'b1;
            state_q <= S_FIN;
          end else begin
            cnt_q   <= '0;
            state_q <= S_RUN;
          end
        end
        S_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(ITER-1)) state_q <= S_FIX;
        end
        S_FIX: begin
          ovf_q   <= po_ovf;
          quo_q   <= po_quo;
          rem_q   <= po_rem;
          cc34_q  <= po_cc34;
          state_q <= S_FIN;
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o       = state_q != S_IDLE;
  assign done_o       = state_q == S_FIN;
  assign wr_r_en_o    = done_o && !ovf_q;
  assign wr_r1_en_o   = done_o && !ovf_q && pair_q;
  assign wr_r_addr_o  = reg_q;
  assign wr_r1_addr_o = reg_q | REG_W'(1);
  assign wr_r_data_o  = pair_q ? rem_q : quo_q;
  assign wr_r1_data_o = quo_q;
  assign cc2_we_o     = done_o;
  assign cc2_o        = done_o && ovf_q;
  assign cc34_we_o    = done_o && !ovf_q;
  assign cc34_o       = cc34_q;
  assign trap_o       = done_o && ovf_q && mask_q;
  assign trap_vec_o   = TRAP_VEC;
endmodule

// File: rtl/regdiv_unit_chk.sv
module regdiv_unit_chk #(
  parameter int XLEN  = 32,
  parameter int REG_W = 4,
  parameter int VEC_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [XLEN-1:0]  rd_r_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             wr_r_en_o,
  input logic [REG_W-1:0] wr_r_addr_o,
  input logic [XLEN-1:0]  wr_r_data_o,
  input logic             wr_r1_en_o,
  input logic [XLEN-1:0]  wr_r1_data_o,
  input logic             cc2_o,
  input logic             cc34_we_o,
  input logic [1:0]       cc34_o,
  input logic             trap_o,
  input logic [VEC_W-1:0] trap_vec_o
);
  logic dvd_sign_q;
  logic [XLEN-1:0] q_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dvd_sign_q <= 1'b0;
    else if (start_i && !busy_o) dvd_sign_q <= rd_r_i[XLEN-1];
  end

  assign q_seen = wr_r1_en_o ? wr_r1_data_o : wr_r_data_o;

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);
  p_no_write_ovf_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && cc2_o |-> !wr_r_en_o && !wr_r1_en_o && !cc34_we_o);
  p_write_at_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_r_en_o || wr_r1_en_o) |-> done_o);
  p_pair_even_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_r1_en_o |-> wr_r_en_o && !wr_r_addr_o[0]);
  p_cc_code_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc34_we_o |-> cc34_o != 2'b11 && !cc2_o);
  p_cc_sign_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc34_we_o |-> ((cc34_o == 2'b01) == q_seen[XLEN-1]) && ((cc34_o == 2'b00) == (q_seen == '0)));
  p_rem_sign_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_r1_en_o && wr_r_data_o != '0 |-> wr_r_data_o[XLEN-1] == dvd_sign_q);
  p_trap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> done_o && cc2_o && trap_vec_o == VEC_W'(8'h43));
endmodule

bind regdiv_unit regdiv_unit_chk #(.XLEN(XLEN), .REG_W(REG_W), .VEC_W(VEC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .rd_r_i       (rd_r_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .wr_r_en_o    (wr_r_en_o),
  .wr_r_addr_o  (wr_r_addr_o),
  .wr_r_data_o  (wr_r_data_o),
  .wr_r1_en_o   (wr_r1_en_o),
  .wr_r1_data_o (wr_r1_data_o),
  .cc2_o        (cc2_o),
  .cc34_we_o    (cc34_we_o),
  .cc34_o       (cc34_o),
  .trap_o       (trap_o),
  .trap_vec_o   (trap_vec_o)
);

// File: tb/regdiv_unit_bench.sv
module regdiv_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LAT_LONG   = 34;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        op_word_i = 1'b0;
  logic [3:0]  reg_sel_i = '0;
  logic [31:0] divisor_i = '0;
  logic [31:0] rd_r_i = '0;
  logic [31:0] rd_r1_i = '0;
  logic        trap_mask_i = 1'b0;
  logic        busy_o, done_o, wr_r_en_o, wr_r1_en_o;
  logic [3:0]  wr_r_addr_o, wr_r1_addr_o;
  logic [31:0] wr_r_data_o, wr_r1_data_o;
  logic        cc2_we_o, cc2_o, cc34_we_o, trap_o;
  logic [1:0]  cc34_o;
  logic [7:0]  trap_vec_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  regdiv_unit u_regdiv_unit (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic word, input logic [3:0] r, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] dv, input logic mask,
                        input string tag, input bit poke);
    logic [63:0] dvd, dsr, dm, sm;
    longint sd, ss, q, rm;
    bit pair, ovf;
    int lat;
    logic [1:0] ecc;
    pair = word && !r[0];
    dvd = pair ? {a, b} : {{32{a[31]}}, a};
    dsr = word ? {{32{dv[31]}}, dv} : {{48{dv[15]}}, dv[15:0]};
    dm = dvd[63] ? -dvd : dvd;
    sm = dsr[63] ? -dsr : dsr;
    q = 0; rm = 0;
    if (sm == 0 || (dm >> 32) >= sm) begin
      ovf = 1'b1; lat = 1;
    end else begin
      sd = dvd; ss = dsr;
      q = sd / ss; rm = sd % ss;
      ovf = (q > 64'sd2147483647) || (q < -64'sd2147483648);
      lat = LAT_LONG;
    end
    ecc = (q == 0) ? 2'b00 : (q < 0) ? 2'b01 : 2'b10;

    @(negedge clk_i);
    start_i = 1'b1; op_word_i = word; reg_sel_i = r;
    rd_r_i = a; rd_r1_i = b; divisor_i = dv; trap_mask_i = mask;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk_i);
      if (poke && k == 3) begin
        start_i = 1'b1; op_word_i = 1'b1; reg_sel_i = 4'd6;
        rd_r_i = 32'h1234; rd_r1_i = 32'h5678; divisor_i = 32'd3; trap_mask_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      if (k < lat) begin
        // R8/R9: no completion or write before the expected cycle
        chk(!done_o && busy_o && !wr_r_en_o && !wr_r1_en_o && !trap_o,
            {tag, " R8 early"}, {done_o, wr_r_en_o, trap_o}, 0);
      end else begin
        chk(done_o && busy_o, {tag, " R8 done"}, done_o, 1);
        chk(cc2_we_o && cc2_o == ovf, {tag, " R5 cc2"}, cc2_o, ovf);
        chk(cc34_we_o == !ovf, {tag, " R6 cc34_we"}, cc34_we_o, !ovf);
        if (!ovf) chk(cc34_o == ecc, {tag, " R6 cc34"}, cc34_o, ecc);
        chk(trap_o == (ovf && mask), {tag, " R7 trap"}, trap_o, ovf && mask);
        chk(trap_vec_o == 8'h43, {tag, " R7 vec"}, trap_vec_o, 8'h43);
        chk(wr_r_en_o == !ovf, {tag, " R5 wr_r_en"}, wr_r_en_o, !ovf);
        chk(wr_r1_en_o == (!ovf && pair), {tag, " R3 wr_r1_en"}, wr_r1_en_o, !ovf && pair);
        if (!ovf) begin
          chk(wr_r_addr_o == r, {tag, " R1 addr"}, wr_r_addr_o, r);
          if (pair) begin
            chk(wr_r_data_o == rm[31:0], {tag, " R2 rem"}, wr_r_data_o, rm[31:0]);
            chk(wr_r1_data_o == q[31:0], {tag, " R1 quo"}, wr_r1_data_o, q[31:0]);
            chk(wr_r1_addr_o == (r | 4'd1), {tag, " R1 addr1"}, wr_r1_addr_o, r | 4'd1);
          end else begin
            chk(wr_r_data_o == q[31:0], {tag, " R4 quo"}, wr_r_data_o, q[31:0]);
          end
        end
      end
    end
    start_i = 1'b0;
    @(negedge clk_i);
    chk(!done_o && !busy_o, {tag, " R9 idle"}, {done_o, busy_o}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk(!done_o && !busy_o && !trap_o && !wr_r_en_o && !wr_r1_en_o && !cc2_we_o && !cc34_we_o,
        "R10 reset", {done_o, busy_o, wr_r_en_o}, 0);
    rst_ni = 1'b1;
    run_op(1, 4'd2, 32'h0, 32'd100, 32'd7, 0, "R1 pair pos", 0);
    run_op(1, 4'd2, 32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'd7, 0, "R2 neg dividend", 0);
    run_op(1, 4'd8, 32'h0, 32'd100, 32'hFFFF_FFF9, 0, "R2 neg divisor", 0);
    run_op(1, 4'd5, 32'hFFFF_FFCE, 32'hDEAD_BEEF, 32'hFFFF_FFFB, 1, "R3 odd word", 0);
    run_op(0, 4'd4, 32'd1000, 32'hCAFE_0000, 32'h1234_FFF6, 0, "R4 half even", 0);
    run_op(0, 4'd3, 32'd3, 32'h0, 32'h7777_000A, 0, "R6 zero quo", 0);
    run_op(1, 4'd0, 32'd9, 32'd9, 32'h0, 1, "R5 zero div", 0);
    run_op(1, 4'd10, 32'h0, 32'h8000_0000, 32'd1, 0, "R5 range pos", 0);
    run_op(1, 4'd12, 32'hFFFF_FFFF, 32'h8000_0000, 32'd1, 0, "R5 min ok", 0);
    run_op(0, 4'd7, 32'h8000_0000, 32'h0, 32'h0000_FFFF, 1, "R7 half ovf", 0);
    run_op(1, 4'd14, 32'd5, 32'd0, 32'd3, 1, "R8 fast ovf", 0);
    run_op(1, 4'd2, 32'h0000_0001, 32'h2345_6789, 32'h7FFF_FFF3, 0, "R2 big", 0);
    run_op(1, 4'd6, 32'h0, 32'd100, 32'd7, 0, "R9 busy poke", 1);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule